// File: doc/BRIEF.md
# Narrow/Wide Bus Lane Steering

This block sits between a 16-bit internal word interface and a parallel bus with two byte lanes. Each lane carries its own odd-parity bit. A mode register selects narrow (one byte per transfer) or wide (two bytes per transfer) operation. A two-bit phase input classifies every transfer as data, command, status or message. Wide operation applies only to the data phase. The other three phases always use the low lane alone.

On transmit, the block registers the word onto the lanes and generates parity. A lane that does not carry the transfer is released, which means its enable is low and its data and parity are all ones.

On receive, the block checks parity on every active lane and presents the assembled word. A wide data receive can end with only the low byte valid. In that case the byte is kept in a one-byte residue register and a flag is set to show that it is held. Reading the residue clears the flag. Writing zero to the wide-mode bit also clears the flag. A sticky parity-error flag records any parity mismatch until software clears it.

Top module: `lane_steer`

## Requirements
- R1: After reset, wide mode is 0 and both the residue flag and the parity-error flag are 0. `rd_valid` is 0, both lane enables are 0, and both lanes read the released level: data all ones and parity 1.
- R2: A transmit with `tx_valid` high drives `tx_word[7:0]` on the low lane one cycle later with `lo_oe`=1. The lane's parity is odd over its byte (`lo_par` = ~^byte). With no transmit the low lane returns to the released level.
- R3: When wide mode is 1 and `phase`=2'b00 (data), a transmit also drives `tx_word[15:8]` on the high lane with `hi_oe`=1 and odd parity. Otherwise the high lane is released.
- R4: Phases 2'b01 (command), 2'b10 (status) and 2'b11 (message) use only the low lane, whatever the wide-mode setting.
- R5: A narrow receive or a non-data receive presents `rd_word` = {8'h00, rx_lo} with `rd_wide`=0 one cycle after `rx_valid`. In these receives the high lane and its parity are ignored.
- R6: A wide data receive without `rx_odd_end` presents `rd_word` = {rx_hi, rx_lo} with `rd_wide`=1 one cycle later. When `rd_valid` is 0, `rd_word` and `rd_wide` read 0.
- R7: A parity mismatch on any active lane sets `perr` one cycle later. `perr` stays set until `perr_clr`. If a set and a clear fall in the same cycle, the set wins.
- R8: A wide data receive with `rx_odd_end`=1 stores `rx_lo` in the residue register and sets `residue_full`. It produces no `rd_valid`, and the high lane is not parity-checked. In narrow mode or non-data phases, `rx_odd_end` is ignored.
- R9: `residue_rd` clears `residue_full` one cycle later, while `residue_byte` keeps the held byte. If a store falls in the same cycle, the store wins.
- R10: `mode_wr` loads `mode_wide` into wide mode. Writing 0 clears `residue_full`, and this clear wins over a same-cycle store. A mode write affects only transfers in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the wide-mode bit |
| mode_wide | input | 1 | Value written to the wide-mode bit |
| phase | input | 2 | Transfer phase: 00 data, 01 command, 10 status, 11 message |
| tx_valid | input | 1 | Transmit the word this cycle |
| tx_word | input | 16 | Word to transmit, low byte in [7:0] |
| lo_oe | output | 1 | Low lane driven |
| lo_data | output | 8 | Low lane byte |
| lo_par | output | 1 | Low lane parity |
| hi_oe | output | 1 | High lane driven |
| hi_data | output | 8 | High lane byte |
| hi_par | output | 1 | High lane parity |
| rx_valid | input | 1 | A received transfer is on the lanes |
| rx_odd_end | input | 1 | Wide receive ends with only the low byte valid |
| rx_lo | input | 8 | Received low lane byte |
| rx_lo_par | input | 1 | Received low lane parity |
| rx_hi | input | 8 | Received high lane byte |
| rx_hi_par | input | 1 | Received high lane parity |
| rd_valid | output | 1 | Received word available |
| rd_wide | output | 1 | Received word holds two bytes |
| rd_word | output | 16 | Received word |
| wide_mode | output | 1 | Current wide-mode bit |
| residue_full | output | 1 | Residue register holds a valid byte |
| residue_byte | output | 8 | Residue register contents |
| residue_rd | input | 1 | Residue read strobe; clears the flag |
| perr_clr | input | 1 | Clears the parity-error flag |
| perr | output | 1 | Sticky parity-error flag |

## Verification
Three functions can land on the residue flag in the same cycle: storing an odd-ending wide byte, reading the residue, and writing zero to the wide-mode bit. The parity-error flag has a similar collision between a set and a clear. Directed cycles put an odd-ending wide receive together with a wide-mode clear, and separately together with a residue read. Randomized traffic then drives all of these strobes at high rates so that the collisions recur many times. In every cycle the bench model applies the stated priorities, clear over store over read and set over clear, and compares the flag and the held byte.

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic            mode_wide,
  input  logic [1:0]      phase,
  input  logic            tx_valid,
  input  logic [2*BW-1:0] tx_word,
  output logic            lo_oe,
  output logic [BW-1:0]   lo_data,
  output logic            lo_par,
  output logic            hi_oe,
  output logic [BW-1:0]   hi_data,
  output logic            hi_par,
  input  logic            rx_valid,
  input  logic            rx_odd_end,
  input  logic [BW-1:0]   rx_lo,
  input  logic            rx_lo_par,
  input  logic [BW-1:0]   rx_hi,
  input  logic            rx_hi_par,
  output logic            rd_valid,
  output logic            rd_wide,
  output logic [2*BW-1:0] rd_word,
  output logic            wide_mode,
  output logic            residue_full,
  output logic [BW-1:0]   residue_byte,
  input  logic            residue_rd,
  input  logic            perr_clr,
  output logic            perr
);
  localparam logic [1:0] PH_DATA = 2'b00;

  logic wide_dp, odd_store, keep_word, mode_clr, lo_bad, hi_bad;

  assign wide_dp   = wide_mode && (phase == PH_DATA);
  assign odd_store = rx_valid && wide_dp && rx_odd_end;
  assign keep_word = rx_valid && !odd_store;
  assign mode_clr  = mode_wr && !mode_wide;
  assign lo_bad    = rx_valid && (rx_lo_par != ~^rx_lo);
  assign hi_bad    = rx_valid && wide_dp && !rx_odd_end && (rx_hi_par != ~^rx_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_oe   <= 1'b0;
      lo_data <= '1;
      lo_par  <= 1'b1;
      hi_oe   <= 1'b0;
      hi_data <= '1;
      hi_par  <= 1'b1;
    end else begin
      lo_oe   <= tx_valid;
      lo_data <= tx_valid ? tx_word[BW-1:0] : '1;
      lo_par  <= tx_valid ? ~^tx_word[BW-1:0] : 1'b1;
      hi_oe   <= tx_valid && wide_dp;
      hi_data <= (tx_valid && wide_dp) ? tx_word[2*BW-1:BW] : '1;
      hi_par  <= (tx_valid && wide_dp) ? ~^tx_word[2*BW-1:BW] : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_wide  <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= keep_word;
      rd_wide  <= keep_word && wide_dp;
      if (!keep_word)   rd_word <= '0;
      else if (wide_dp) rd_word <= {rx_hi, rx_lo};
      else              rd_word <= {{BW{1'b0}}, rx_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_mode    <= 1'b0;
      residue_full <= 1'b0;
      residue_byte <= '0;
      perr         <= 1'b0;
    end else begin
      if (mode_wr) wide_mode <= mode_wide;
      if (odd_store) residue_byte <= rx_lo;
      if (mode_clr)        residue_full <= 1'b0;
      else if (odd_store)  residue_full <= 1'b1;
      else if (residue_rd) residue_full <= 1'b0;
      if (lo_bad || hi_bad) perr <= 1'b1;
      else if (perr_clr)    perr <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_wr,
  input logic            mode_wide,
  input logic [1:0]      phase,
  input logic            tx_valid,
  input logic            lo_oe,
  input logic [BW-1:0]   lo_data,
  input logic            lo_par,
  input logic            hi_oe,
  input logic [BW-1:0]   hi_data,
  input logic            hi_par,
  input logic            rx_valid,
  input logic            rx_odd_end,
  input logic            rd_valid,
  input logic            wide_mode,
  input logic            residue_full,
  input logic            residue_rd,
  input logic            perr_clr,
  input logic            perr
);
  a_r2_lo_parity_odd: assert property (@(posedge clk) disable iff (!rst_n)
    lo_oe |-> (lo_par == ~^lo_data));
  a_r3_hi_parity_odd: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe |-> (hi_par == ~^hi_data));
  a_r2_narrow_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !wide_mode) |=> (lo_oe && !hi_oe && hi_data == '1 && hi_par));
  a_r4_nondata_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && phase != 2'b00) |=> (lo_oe && !hi_oe));
  a_r7_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !perr_clr) |=> perr);
  a_r8_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_odd_end && wide_mode && phase == 2'b00 && !(mode_wr && !mode_wide))
      |=> (residue_full && !rd_valid));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (residue_rd && !rx_valid) |=> !residue_full);
  a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !mode_wide) |=> (!residue_full && !wide_mode));
endmodule

bind lane_steer lane_steer_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wide(mode_wide),
  .phase(phase), .tx_valid(tx_valid), .lo_oe(lo_oe), .lo_data(lo_data),
  .lo_par(lo_par), .hi_oe(hi_oe), .hi_data(hi_data), .hi_par(hi_par),
  .rx_valid(rx_valid), .rx_odd_end(rx_odd_end), .rd_valid(rd_valid),
  .wide_mode(wide_mode), .residue_full(residue_full), .residue_rd(residue_rd),
  .perr_clr(perr_clr), .perr(perr)
);

// File: tb/lane_steer_tb.sv
module lane_steer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, mode_wide = 0, tx_valid = 0, rx_valid = 0, rx_odd_end = 0;
  logic rx_lo_par = 0, rx_hi_par = 0, residue_rd = 0, perr_clr = 0;
  logic [1:0] phase = 0;
  logic [15:0] tx_word = 0;
  logic [7:0] rx_lo = 0, rx_hi = 0;
  logic lo_oe, lo_par, hi_oe, hi_par, rd_valid, rd_wide, wide_mode, residue_full, perr;
  logic [7:0] lo_data, hi_data, residue_byte;
  logic [15:0] rd_word;

  int errors = 0, checks = 0, cycles = 0;

  lane_steer u_dut (.*);

  always #5 clk = ~clk;

  // reference model state
  logic m_lo_oe = 0, m_lop = 1, m_hi_oe = 0, m_hip = 1, m_rdv = 0, m_rdw = 0;
  logic m_wide = 0, m_flag = 0, m_perr = 0;
  logic [7:0] m_lo = 8'hFF, m_hi = 8'hFF, m_res = 0;
  logic [15:0] m_word = 0;
  logic wd, odd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo_oe = 0; m_lo = 8'hFF; m_lop = 1; m_hi_oe = 0; m_hi = 8'hFF; m_hip = 1;
      m_rdv = 0; m_rdw = 0; m_word = 0; m_wide = 0; m_flag = 0; m_res = 0; m_perr = 0;
    end else begin
      wd  = m_wide && phase == 2'b00;
      odd = rx_valid && wd && rx_odd_end;
      m_lo_oe = tx_valid;
      m_lo  = tx_valid ? tx_word[7:0] : 8'hFF;
      m_lop = tx_valid ? ~^tx_word[7:0] : 1'b1;
      m_hi_oe = tx_valid && wd;
      m_hi  = m_hi_oe ? tx_word[15:8] : 8'hFF;
      m_hip = m_hi_oe ? ~^tx_word[15:8] : 1'b1;
      m_rdv = rx_valid && !odd;
      m_rdw = m_rdv && wd;
      m_word = !m_rdv ? 16'h0 : (wd ? {rx_hi, rx_lo} : {8'h00, rx_lo});
      if (rx_valid && ((rx_lo_par != ~^rx_lo) ||
          (wd && !rx_odd_end && rx_hi_par != ~^rx_hi))) m_perr = 1;
      else if (perr_clr) m_perr = 0;
      if (odd) m_res = rx_lo;
      if (mode_wr && !mode_wide) m_flag = 0;
      else if (odd) m_flag = 1;
      else if (residue_rd) m_flag = 0;
      if (mode_wr) m_wide = mode_wide;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare(bit in_reset);
    if (in_reset) begin
      chk("R1 lanes", {lo_oe, hi_oe, lo_par, hi_par, lo_data, 4'h0}, {2'b00, 2'b11, 8'hFF, 4'h0});
      chk("R1 flags", {rd_valid, wide_mode, residue_full, perr}, 4'h0);
      chk("R1 hi_data", hi_data, 8'hFF);
    end else begin
      chk("R2 low lane", {lo_oe, lo_par, lo_data}, {m_lo_oe, m_lop, m_lo});
      chk("R3 high lane", {hi_oe, hi_par, hi_data}, {m_hi_oe, m_hip, m_hi});
      chk("R6 rd_word", rd_word, m_word);
      chk("R5 rd_wide", rd_wide, m_rdw);
      chk("R8 rd_valid", rd_valid, m_rdv);
      chk("R7 perr", perr, m_perr);
      chk("R9 residue_full", residue_full, m_flag);
      chk("R8 residue_byte", residue_byte, m_res);
      chk("R10 wide_mode", wide_mode, m_wide);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle();
    mode_wr = 0; tx_valid = 0; rx_valid = 0; rx_odd_end = 0; residue_rd = 0; perr_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare(0);
  endtask

  task automatic rx(logic [1:0] ph, logic [7:0] lo, logic [7:0] hi, bit oddend, bit badlo, bit badhi);
    phase = ph; rx_valid = 1; rx_lo = lo; rx_hi = hi; rx_odd_end = oddend;
    rx_lo_par = ~^lo ^ badlo; rx_hi_par = ~^hi ^ badhi;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare(1);                                     // R1 reset state
    rst_n = 1;
    step();
    // R2 narrow transmit, data phase
    phase = 0; tx_valid = 1; tx_word = 16'hA53C; step(); idle();
    // R4 command phase in narrow mode
    phase = 1; tx_valid = 1; tx_word = 16'h1234; step(); idle();
    // R5 narrow receive with a bad high parity that must be ignored
    rx(2'b00, 8'h5A, 8'hC3, 0, 0, 1); step(); idle(); step();
    // R10 enable wide
    mode_wr = 1; mode_wide = 1; step(); idle();
    // R3 wide data transmit
    phase = 0; tx_valid = 1; tx_word = 16'hBEEF; step(); idle();
    // R4 status and message phases stay narrow in wide mode
    phase = 2; tx_valid = 1; tx_word = 16'h7788; step();
    phase = 3; tx_word = 16'h0102; step(); idle();
    // R6 wide data receive
    rx(2'b00, 8'h11, 8'h22, 0, 0, 0); step(); idle();
    // R7 high lane parity error, then set and clear together
    rx(2'b00, 8'h33, 8'h44, 0, 0, 1); step(); idle(); step();
    rx(2'b01, 8'h01, 8'h00, 0, 1, 0); perr_clr = 1; step(); idle();
    perr_clr = 1; step(); idle();
    // R8 odd end stores the residue, high parity not checked
    rx(2'b00, 8'h9C, 8'h00, 1, 0, 1); step(); idle(); step();
    // R9 read clears the flag, byte retained
    residue_rd = 1; step(); idle(); step();
    // R9 store wins over a same-cycle read
    rx(2'b00, 8'h6E, 8'h00, 1, 0, 0); residue_rd = 1; step(); idle(); step();
    // R10 clear of wide mode wins over a same-cycle store
    rx(2'b00, 8'h7F, 8'h00, 1, 0, 0); mode_wr = 1; mode_wide = 0; step(); idle(); step();
    // R8 odd end ignored in narrow mode
    rx(2'b00, 8'h42, 8'h00, 1, 0, 0); step(); idle(); step();
    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      mode_wr = ($urandom % 8) == 0; mode_wide = ($urandom % 4) != 0;
      phase = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      tx_valid = $urandom; tx_word = 16'($urandom);
      rx_valid = $urandom; rx_odd_end = ($urandom % 3) == 0;
      rx_lo = 8'($urandom); rx_hi = 8'($urandom);
      rx_lo_par = ~^rx_lo ^ (($urandom % 12) == 0);
      rx_hi_par = ~^rx_hi ^ (($urandom % 12) == 0);
      residue_rd = ($urandom % 5) == 0; perr_clr = ($urandom % 6) == 0;
      step();
    end
    idle(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule